// File: doc/BRIEF.md
# Crossover Front-Panel Control Sequencer

This block turns the front-panel controls of a two-way digital crossover into register values for the audio path. It decodes one quadrature rotary encoder and its push button, and it takes readings from a digitised volume potentiometer. From these it drives the active input-source number, a lowpass trim level, a master volume with mute, and an enable for the output relays. The downstream mux, the gain stages and the display logic read these registers directly.

The single encoder has two roles. Normally rotation moves through the input sources. A button press turns it into a trim control that raises or lowers the lowpass branch against the highpass branch. A second press, or a stretch of inactivity, returns it to source selection. The pot's lowest positions mean mute. The source number held in non-volatile storage is loaded when reset ends. The output relays stay open until the selected input has been valid for a settle delay, so no turn-on pop reaches the speakers.

Top module: `xover_panel_ctrl`

## Requirements
- R1: While reset is held, `src_sel`=0, `trim_lvl`=0, `trim_mode`=0, `mute`=1, `vol_lvl`=0, `relay_en`=0 and `disp_rate`=0. On the first clock after reset is released, `src_sel` loads `saved_src`.
- R2: In source mode (`trim_mode`=0), a full clockwise detent increments `src_sel` modulo NUM_SRC, so the last source wraps to 0. On {enc_a,enc_b} a clockwise detent is 11→01→00→10→11. A counter-clockwise detent (11→10→00→01→11) decrements `src_sel`, and 0 wraps to NUM_SRC-1.
- R3: The encoder and button inputs are synchronised and must then hold a new level for DEB_CYC consecutive clocks to be accepted. A step counts only when the encoder returns to rest (11) after four same-direction transitions. A partial turn that returns to rest (such as 11→01→11) produces no step.
- R4: A button press toggles `trim_mode`. The button is active high, and a press is a rising edge of the debounced level. In trim mode, a clockwise detent adds 1 to `trim_lvl`, a counter-clockwise detent subtracts 1, and `src_sel` stays unchanged. In source mode, `trim_lvl` stays unchanged.
- R5: `trim_lvl` is signed and saturates at TRIM_MAX and at TRIM_MIN. It never wraps.
- R6: In trim mode, if IDLE_CYC clocks pass with no step and no press, the block returns to source mode.
- R7: On a clock with `pot_valid`=1, a `pot_value` at or below MUTE_THR gives `mute`=1 and `vol_lvl`=0. Any higher value gives `mute`=0 and `vol_lvl`=`pot_value`. Changes of `pot_value` while `pot_valid`=0 have no effect.
- R8: `relay_en` rises only after `input_valid` has been high for SETTLE_CYC consecutive clocks. This applies both after reset and after any low period. `relay_en` falls on the clock after `input_valid` goes low.
- R9: `disp_rate` shows `rate_code` registered by one clock while `input_valid`=1, and shows 0 otherwise. The rate codes are 0 none, 1 44.1 kHz, 2 48 kHz and 3 unsupported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder phase A, asynchronous, rest high |
| enc_b | input | 1 | Encoder phase B, asynchronous, rest high |
| enc_btn | input | 1 | Encoder push button, asynchronous, high when pressed |
| saved_src | input | SRC_W | Last-used source from non-volatile storage |
| pot_value | input | POT_W | Digitised potentiometer position |
| pot_valid | input | 1 | Strobe: `pot_value` holds a new reading |
| input_valid | input | 1 | Selected digital input is locked and usable |
| rate_code | input | 2 | Detected sample-rate code |
| src_sel | output | SRC_W | Active input source |
| trim_lvl | output | TRIM_W | Signed lowpass trim level in steps |
| trim_mode | output | 1 | 1 while the encoder adjusts the trim |
| vol_lvl | output | POT_W | Master volume, 0 when muted |
| mute | output | 1 | Master mute |
| relay_en | output | 1 | Close the output relays |
| disp_rate | output | 2 | Sample-rate code for the display |

## Verification
A corrupted quarter-step accumulator or a stuck mode flag shows up within one detent as a wrong `src_sel` or `trim_lvl`, or as a step that lands on the wrong register. A broken inactivity counter shows up IDLE_CYC clocks after the last press as `trim_mode` failing to drop, or dropping too early. A faulty settle counter is visible at SETTLE_CYC clocks after reset or after a loss of `input_valid`, where `relay_en` rises at the wrong time. A bad saturation or wrap bound appears on the first detent past a limit.

// File: rtl/xpc_pkg.sv
package xpc_pkg;
   typedef enum logic {
      MODE_SRC  = 1'b0,
      MODE_TRIM = 1'b1
   } xpc_mode_e;

   localparam logic [1:0] ENC_REST = 2'b11;
endpackage

// File: rtl/xpc_sync_debounce.sv
module xpc_sync_debounce #(
   parameter int           N       = 1,
   parameter int           DEB_CYC = 8,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   output logic [N-1:0] clean
);
   localparam int CNT_W = $clog2(DEB_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYC - 1);

   initial begin
      assert (DEB_CYC >= 1) else $error("DEB_CYC must be at least 1");
      assert (N >= 1) else $error("N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic             s1_q, s2_q, st_q;
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_q  <= RST_VAL[i];
            s2_q  <= RST_VAL[i];
            st_q  <= RST_VAL[i];
            cnt_q <= '0;
         end else begin
            s1_q <= raw[i];
            s2_q <= s1_q;
            if (s2_q == st_q) begin
               cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
               st_q  <= s2_q;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
      assign clean[i] = st_q;
   end
endmodule

// File: rtl/xpc_quad_decoder.sv
module xpc_quad_decoder
   import xpc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ab,
   output logic       step_up,
   output logic       step_dn
);
   logic [1:0]        prev_q;
   logic signed [3:0] acc_q;
   logic signed [3:0] delta;
   logic signed [3:0] sum;

   always_comb begin
      unique case ({prev_q, ab})
         4'b1101, 4'b0100, 4'b0010, 4'b1011: delta = 4'sd1;
         4'b1110, 4'b1000, 4'b0001, 4'b0111: delta = -4'sd1;
         default:                            delta = 4'sd0;
      endcase
      sum = acc_q + delta;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= ENC_REST;
         acc_q   <= '0;
         step_up <= 1'b0;
         step_dn <= 1'b0;
      end else begin
         prev_q  <= ab;
         step_up <= 1'b0;
         step_dn <= 1'b0;
         if (ab != prev_q) begin
            if (ab == ENC_REST) begin
               step_up <= (sum == 4'sd4);
               step_dn <= (sum == -4'sd4);
               acc_q   <= '0;
            end else begin
               acc_q <= sum;
            end
         end
      end
   end
endmodule

// File: rtl/xpc_relay_seq.sv
module xpc_relay_seq #(
   parameter int SETTLE_CYC = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic input_valid,
   output logic relay_en
);
   localparam int CNT_W = $clog2(SETTLE_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(SETTLE_CYC);

   logic [CNT_W-1:0] cnt_q;

   initial assert (SETTLE_CYC >= 1) else $error("SETTLE_CYC must be at least 1");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!input_valid) begin
         cnt_q <= '0;
      end else if (cnt_q != CNT_DONE) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign relay_en = (cnt_q == CNT_DONE);
endmodule

// File: rtl/xover_panel_ctrl.sv
module xover_panel_ctrl
   import xpc_pkg::*;
#(
   parameter int NUM_SRC    = 4,
   parameter int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   parameter int TRIM_W     = 6,
   parameter int TRIM_MIN   = -12,
   parameter int TRIM_MAX   = 12,
   parameter int POT_W      = 8,
   parameter int MUTE_THR   = 0,
   parameter int DEB_CYC    = 1000,
   parameter int IDLE_CYC   = 500000,
   parameter int SETTLE_CYC = 1000000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enc_a,
   input  logic                     enc_b,
   input  logic                     enc_btn,
   input  logic [SRC_W-1:0]         saved_src,
   input  logic [POT_W-1:0]         pot_value,
   input  logic                     pot_valid,
   input  logic                     input_valid,
   input  logic [1:0]               rate_code,
   output logic [SRC_W-1:0]         src_sel,
   output logic signed [TRIM_W-1:0] trim_lvl,
   output logic                     trim_mode,
   output logic [POT_W-1:0]         vol_lvl,
   output logic                     mute,
   output logic                     relay_en,
   output logic [1:0]               disp_rate
);
   localparam logic [SRC_W-1:0]         SRC_LAST = SRC_W'(NUM_SRC - 1);
   localparam logic signed [TRIM_W-1:0] T_MAX    = TRIM_W'(TRIM_MAX);
   localparam logic signed [TRIM_W-1:0] T_MIN    = TRIM_W'(TRIM_MIN);
   localparam logic [POT_W-1:0]         MUTE_V   = POT_W'(MUTE_THR);
   localparam int                       IDLE_W   = $clog2(IDLE_CYC + 1);
   localparam logic [IDLE_W-1:0]        IDLE_END = IDLE_W'(IDLE_CYC - 1);

   initial begin
      assert (NUM_SRC >= 2 && NUM_SRC <= 2**SRC_W) else $error("bad NUM_SRC/SRC_W");
      assert (TRIM_MIN <= 0 && TRIM_MAX >= 0) else $error("trim range must contain 0");
      assert (TRIM_MAX < 2**(TRIM_W-1) && TRIM_MIN >= -(2**(TRIM_W-1)))
         else $error("trim limits exceed TRIM_W");
      assert (MUTE_THR >= 0 && MUTE_THR < 2**POT_W) else $error("bad MUTE_THR");
      assert (IDLE_CYC >= 2) else $error("IDLE_CYC must be at least 2");
   end

   logic [1:0] enc_clean;
   logic       btn_clean, btn_q, press;
   logic       step_up, step_dn;
   logic       loaded_q;
   logic [SRC_W-1:0]  restore;
   logic [IDLE_W-1:0] idle_q;
   xpc_mode_e         mode_q;

   xpc_sync_debounce #(.N(3), .DEB_CYC(DEB_CYC), .RST_VAL(3'b110)) i_deb (
      .clk(clk), .rst_n(rst_n),
      .raw({enc_a, enc_b, enc_btn}),
      .clean({enc_clean, btn_clean})
   );

   xpc_quad_decoder i_quad (
      .clk(clk), .rst_n(rst_n), .ab(enc_clean),
      .step_up(step_up), .step_dn(step_dn)
   );

   xpc_relay_seq #(.SETTLE_CYC(SETTLE_CYC)) i_relay (
      .clk(clk), .rst_n(rst_n), .input_valid(input_valid), .relay_en(relay_en)
   );

   if (NUM_SRC == 2**SRC_W) begin : g_restore_full
      assign restore = saved_src;
   end else begin : g_restore_range
      assign restore = (saved_src <= SRC_LAST) ? saved_src : '0;
   end

   assign press = btn_clean & ~btn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         btn_q    <= 1'b0;
         loaded_q <= 1'b0;
         src_sel  <= '0;
         trim_lvl <= '0;
         mode_q   <= MODE_SRC;
         idle_q   <= '0;
      end else begin
         btn_q    <= btn_clean;
         loaded_q <= 1'b1;
         if (!loaded_q) begin
            src_sel <= restore;
         end else begin
            if (press) begin
               mode_q <= (mode_q == MODE_SRC) ? MODE_TRIM : MODE_SRC;
               idle_q <= '0;
            end else if (mode_q == MODE_TRIM) begin
               if (step_up || step_dn) begin
                  idle_q <= '0;
               end else if (idle_q == IDLE_END) begin
                  mode_q <= MODE_SRC;
                  idle_q <= '0;
               end else begin
                  idle_q <= idle_q + 1'b1;
               end
            end
            if (mode_q == MODE_SRC) begin
               if (step_up)
                  src_sel <= (src_sel == SRC_LAST) ? '0 : src_sel + 1'b1;
               else if (step_dn)
                  src_sel <= (src_sel == '0) ? SRC_LAST : src_sel - 1'b1;
            end else begin
               if (step_up && trim_lvl < T_MAX)
                  trim_lvl <= trim_lvl + 1'b1;
               else if (step_dn && trim_lvl > T_MIN)
                  trim_lvl <= trim_lvl - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vol_lvl   <= '0;
         mute      <= 1'b1;
         disp_rate <= 2'd0;
      end else begin
         disp_rate <= input_valid ? rate_code : 2'd0;
         if (pot_valid) begin
            if (pot_value <= MUTE_V) begin
               mute    <= 1'b1;
               vol_lvl <= '0;
            end else begin
               mute    <= 1'b0;
               vol_lvl <= pot_value;
            end
         end
      end
   end

   assign trim_mode = (mode_q == MODE_TRIM);
endmodule

// File: rtl/xpc_checker.sv
module xpc_checker #(
   parameter int NUM_SRC  = 4,
   parameter int SRC_W    = 2,
   parameter int TRIM_W   = 6,
   parameter int TRIM_MIN = -12,
   parameter int TRIM_MAX = 12
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     input_valid,
   input logic [SRC_W-1:0]         src_sel,
   input logic signed [TRIM_W-1:0] trim_lvl,
   input logic                     trim_mode,
   input logic                     relay_en
);
   localparam logic [SRC_W-1:0]         SRC_LAST = SRC_W'(NUM_SRC - 1);
   localparam logic signed [TRIM_W-1:0] T_MAX    = TRIM_W'(TRIM_MAX);
   localparam logic signed [TRIM_W-1:0] T_MIN    = TRIM_W'(TRIM_MIN);

   logic [1:0]       age_q;
   logic [SRC_W-1:0] prev_src_q, nxt, prv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age_q      <= '0;
         prev_src_q <= '0;
      end else begin
         if (age_q != 2'd2) age_q <= age_q + 1'b1;
         prev_src_q <= src_sel;
      end
   end

   assign nxt = (prev_src_q == SRC_LAST) ? '0 : prev_src_q + 1'b1;
   assign prv = (prev_src_q == '0) ? SRC_LAST : prev_src_q - 1'b1;

   // R2: after the restore cycle, the source moves by one position at a time
   p_src_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd2 && src_sel != prev_src_q) |-> (src_sel == nxt || src_sel == prv));

   // R5: trim stays inside its limits
   p_trim_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trim_lvl <= T_MAX && trim_lvl >= T_MIN));

   // R4: trim changes only when the previous cycle was in trim mode
   p_trim_mode_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(trim_lvl) |-> $past(trim_mode));

   // R8: relays closed only if the input was valid in the previous cycle
   p_relay_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      relay_en |-> $past(input_valid));
endmodule

bind xover_panel_ctrl xpc_checker #(
   .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .TRIM_W(TRIM_W),
   .TRIM_MIN(TRIM_MIN), .TRIM_MAX(TRIM_MAX)
) i_xpc_checker (
   .clk(clk), .rst_n(rst_n), .input_valid(input_valid), .src_sel(src_sel),
   .trim_lvl(trim_lvl), .trim_mode(trim_mode), .relay_en(relay_en)
);

// File: tb/test_xover_panel_ctrl.sv
module test_xover_panel_ctrl;
   localparam int NUM_SRC = 4, SRC_W = 2, TRIM_W = 6, POT_W = 8;
   localparam int DEB = 4, IDLE = 400, SETTLE = 50, MUTE_THR = 2;
   localparam int HOLD = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic enc_a = 1'b1, enc_b = 1'b1, enc_btn = 1'b0;
   logic [SRC_W-1:0] saved_src = 2'd2;
   logic [POT_W-1:0] pot_value = '0;
   logic pot_valid = 1'b0, input_valid = 1'b1;
   logic [1:0] rate_code = 2'd2;
   logic [SRC_W-1:0] src_sel;
   logic signed [TRIM_W-1:0] trim_lvl;
   logic trim_mode, mute, relay_en;
   logic [POT_W-1:0] vol_lvl;
   logic [1:0] disp_rate;

   int tests = 0, fails = 0, cycles = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   xover_panel_ctrl #(
      .NUM_SRC(NUM_SRC), .TRIM_W(TRIM_W), .TRIM_MIN(-3), .TRIM_MAX(3),
      .POT_W(POT_W), .MUTE_THR(MUTE_THR), .DEB_CYC(DEB),
      .IDLE_CYC(IDLE), .SETTLE_CYC(SETTLE)
   ) i_xover_panel_ctrl (
      .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_btn(enc_btn),
      .saved_src(saved_src), .pot_value(pot_value), .pot_valid(pot_valid),
      .input_valid(input_valid), .rate_code(rate_code), .src_sel(src_sel),
      .trim_lvl(trim_lvl), .trim_mode(trim_mode), .vol_lvl(vol_lvl),
      .mute(mute), .relay_en(relay_en), .disp_rate(disp_rate)
   );

   // op[10:9] (0 cw, 1 ccw, 2 press), src[8:7], trim[6:1], mode[0]
   localparam int NV = 19;
   localparam logic [10:0] VEC [NV] = '{
      {2'd0, 2'd3, 6'h00, 1'b0}, {2'd0, 2'd0, 6'h00, 1'b0},
      {2'd1, 2'd3, 6'h00, 1'b0}, {2'd2, 2'd3, 6'h00, 1'b1},
      {2'd0, 2'd3, 6'h01, 1'b1}, {2'd0, 2'd3, 6'h02, 1'b1},
      {2'd0, 2'd3, 6'h03, 1'b1}, {2'd0, 2'd3, 6'h03, 1'b1},
      {2'd2, 2'd3, 6'h03, 1'b0}, {2'd1, 2'd2, 6'h03, 1'b0},
      {2'd2, 2'd2, 6'h03, 1'b1}, {2'd1, 2'd2, 6'h02, 1'b1},
      {2'd1, 2'd2, 6'h01, 1'b1}, {2'd1, 2'd2, 6'h00, 1'b1},
      {2'd1, 2'd2, 6'h3F, 1'b1}, {2'd1, 2'd2, 6'h3E, 1'b1},
      {2'd1, 2'd2, 6'h3D, 1'b1}, {2'd1, 2'd2, 6'h3D, 1'b1},
      {2'd2, 2'd2, 6'h3D, 1'b0}
   };

   task automatic check(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic phase(logic a, logic b, int n);
      enc_a = a;
      enc_b = b;
      wait_cyc(n);
   endtask

   task automatic detent(bit ccw, int n);
      if (!ccw) begin
         phase(0, 1, n); phase(0, 0, n); phase(1, 0, n); phase(1, 1, n);
      end else begin
         phase(1, 0, n); phase(0, 0, n); phase(0, 1, n); phase(1, 1, n);
      end
      wait_cyc(HOLD);
   endtask

   task automatic press();
      enc_btn = 1'b1;
      wait_cyc(20);
      enc_btn = 1'b0;
      wait_cyc(20);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
         end
      end
   end

   initial begin
      wait_cyc(3);
      check("R1 src in reset", int'(src_sel), 0);
      check("R1 trim in reset", int'(trim_lvl), 0);
      check("R1 mode in reset", int'(trim_mode), 0);
      check("R1 mute in reset", int'(mute), 1);
      check("R1 vol in reset", int'(vol_lvl), 0);
      check("R1 relay in reset", int'(relay_en), 0);
      check("R1 rate in reset", int'(disp_rate), 0);
      rst_n = 1'b1;
      wait_cyc(3);
      check("R1 restored src", int'(src_sel), 2);
      check("R9 rate shown", int'(disp_rate), 2);
      wait_cyc(42);
      check("R8 relay before settle", int'(relay_en), 0);
      wait_cyc(10);
      check("R8 relay after settle", int'(relay_en), 1);
      input_valid = 1'b0;
      wait_cyc(1);
      check("R8 relay drops", int'(relay_en), 0);
      check("R9 rate blank when invalid", int'(disp_rate), 0);
      wait_cyc(5);
      input_valid = 1'b1;
      rate_code = 2'd1;
      wait_cyc(45);
      check("R8 relay before resettle", int'(relay_en), 0);
      check("R9 rate 44.1", int'(disp_rate), 1);
      wait_cyc(10);
      check("R8 relay after resettle", int'(relay_en), 1);

      // R2 R4 R5 vector walk
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][10:9] == 2'd2) press();
         else detent(VEC[i][10:9] == 2'd1, HOLD);
         check($sformatf("R2 src vec%0d", i), int'(src_sel), int'(VEC[i][8:7]));
         check($sformatf("R5 trim vec%0d", i), int'(trim_lvl), int'($signed(VEC[i][6:1])));
         check($sformatf("R4 mode vec%0d", i), int'(trim_mode), int'(VEC[i][0]));
      end

      // R3 partial turn and short glitches
      phase(0, 1, HOLD); phase(1, 1, HOLD); wait_cyc(HOLD);
      check("R3 partial turn ignored", int'(src_sel), 2);
      detent(1'b0, 1);
      check("R3 short phases ignored", int'(src_sel), 2);
      detent(1'b0, HOLD);
      check("R3 clean detent counted", int'(src_sel), 3);

      // R6 inactivity timeout
      press();
      check("R6 trim mode entered", int'(trim_mode), 1);
      wait_cyc(300);
      check("R6 still in trim", int'(trim_mode), 1);
      wait_cyc(200);
      check("R6 timeout to source", int'(trim_mode), 0);
      detent(1'b0, HOLD);
      check("R6 source steps again", int'(src_sel), 0);
      check("R4 trim kept in source mode", int'(trim_lvl), -3);

      // R7 potentiometer
      pot_value = 8'd2; pot_valid = 1'b1; wait_cyc(1); pot_valid = 1'b0; wait_cyc(1);
      check("R7 mute at threshold", int'(mute), 1);
      check("R7 vol zero at threshold", int'(vol_lvl), 0);
      pot_value = 8'd3; pot_valid = 1'b1; wait_cyc(1); pot_valid = 1'b0; wait_cyc(1);
      check("R7 unmute above threshold", int'(mute), 0);
      check("R7 vol follows pot", int'(vol_lvl), 3);
      pot_value = 8'd200; wait_cyc(3);
      check("R7 no strobe ignored", int'(vol_lvl), 3);
      pot_value = 8'd0; wait_cyc(3);
      check("R7 no strobe keeps unmuted", int'(mute), 0);

      // R1 second reset with another saved source
      saved_src = 2'd1;
      rst_n = 1'b0;
      wait_cyc(2);
      check("R1 relay open in reset", int'(relay_en), 0);
      rst_n = 1'b1;
      wait_cyc(2);
      check("R1 second restore", int'(src_sel), 1);
      check("R1 trim cleared", int'(trim_lvl), 0);
      check("R1 mute after reset", int'(mute), 1);

      finish_run();
   end
endmodule